// File: doc/BRIEF.md
# Prioritized Interrupt Request Router

This block gathers interrupt requests from a parameterized set of peripheral sources and hands the most urgent one to a single CPU interrupt port. Every source owns a 32-bit control word on a simple register bus. The word holds a software-assigned priority number, an enable bit, a two-bit target selector and a pending-request flag. Peripherals raise requests with one-cycle pulses. Software may also raise or drop a flag through write-one-to-set and write-one-to-clear bits in the same word.

A source can win only when its flag is pending, it is enabled, its target selector names the CPU (code 0) and its priority number is not zero. The router registers the winner's priority and index on its outputs. When the CPU accepts an interrupt it returns the priority it took, and the matching source's flag is cleared. A mode input chooses between two field layouts of the control word, which serve two device generations. The stored state is the same in either mode. Only the packing seen on the bus differs.

Top module: `irq_router`

## Requirements
- R1: With `gen_sel`=0 the control word has the priority in bits 7:0, enable in bit 10 and target in bits 12:11. Bit 24 reads as the request flag, a 1 written to bit 26 sets the flag and a 1 written to bit 25 clears it. Set-bit and clear-bit positions read as 0.
- R2: With `gen_sel`=1 the same stored state is packed with the priority in bits 7:0, the target in bits 13:12 and enable in bit 23. Bit 31 is the request flag, bit 30 is write-one-to-set and bit 29 is write-one-to-clear.
- R3: A write with only the clear bit drops the request flag. A `hw_req` pulse sets it, and wins over a software clear or an acknowledge in the same cycle. A write with neither bit leaves the flag unchanged.
- R4: A source is eligible only when its flag is set, enable is 1, its target code is 0 (CPU) and its priority is not zero.
- R5: Among eligible sources, `irq_valid` is 1, `irq_prio` carries the highest priority number and `irq_src` carries that source's index.
- R6: When eligible sources share the highest priority, the lowest index wins.
- R7: With no eligible source, `irq_valid`, `irq_prio` and `irq_src` are all zero.
- R8: The outputs reflect a register write, request pulse or acknowledge exactly one clock after the edge that updates the control state.
- R9: A `cpu_ack` pulse clears the flag of the lowest-index eligible source whose priority equals `cpu_ack_prio`. An acknowledge with no matching priority changes nothing.
- R10: After synchronous reset, every control word reads as zero and the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_sel | input | 1 | Control-word layout select (0 or 1) |
| hw_req | input | NSRC | Per-source request pulses from peripherals |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | IW | Source index addressed by the bus |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed control word (combinational) |
| cpu_ack | input | 1 | CPU accepts an interrupt |
| cpu_ack_prio | input | 8 | Priority number the CPU accepted |
| irq_valid | output | 1 | An eligible request is presented |
| irq_prio | output | 8 | Priority number of the winner, zero when idle |
| irq_src | output | IW | Index of the winner, zero when idle |

## Verification
A corrupted request flag shows up one clock later as a wrong winner on `irq_prio`/`irq_src`. It also shows at once in the flag bit of a bus read of that source. A fault in the tie or comparison logic surfaces as the wrong index whenever two sources carry equal or neighbouring priorities. A stuck output register shows up as a delivery that lags or leads the write by a cycle. The directed scenarios therefore sample both the cycle just after each state change and the cycle after that.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int PRIO_BITS = 8;
    localparam int TGT_BITS  = 2;
    localparam logic [TGT_BITS-1:0] TGT_CPU = '0;

    // layout 0 field positions
    localparam int L0_EN  = 10;
    localparam int L0_TGT = 11;
    localparam int L0_REQ = 24;
    localparam int L0_CLR = 25;
    localparam int L0_SET = 26;
    // layout 1 field positions
    localparam int L1_TGT = 12;
    localparam int L1_EN  = 23;
    localparam int L1_CLR = 29;
    localparam int L1_SET = 30;
    localparam int L1_REQ = 31;

    typedef struct packed {
        logic [PRIO_BITS-1:0] prio;
        logic                 en;
        logic [TGT_BITS-1:0]  tgt;
        logic                 req;
    } src_cfg_t;

    typedef struct packed {
        logic [PRIO_BITS-1:0] prio;
        logic                 en;
        logic [TGT_BITS-1:0]  tgt;
        logic                 set;
        logic                 clr;
    } src_wr_t;

    function automatic src_wr_t unpack_word(input logic mode, input logic [31:0] w);
        src_wr_t r;
        r.prio = w[PRIO_BITS-1:0];
        if (!mode) begin
            r.en  = w[L0_EN];
            r.tgt = w[L0_TGT +: TGT_BITS];
            r.set = w[L0_SET];
            r.clr = w[L0_CLR];
        end else begin
            r.en  = w[L1_EN];
            r.tgt = w[L1_TGT +: TGT_BITS];
            r.set = w[L1_SET];
            r.clr = w[L1_CLR];
        end
        return r;
    endfunction

    function automatic logic [31:0] pack_word(input logic mode, input src_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[PRIO_BITS-1:0] = c.prio;
        if (!mode) begin
            w[L0_EN]              = c.en;
            w[L0_TGT +: TGT_BITS] = c.tgt;
            w[L0_REQ]             = c.req;
        end else begin
            w[L1_EN]              = c.en;
            w[L1_TGT +: TGT_BITS] = c.tgt;
            w[L1_REQ]             = c.req;
        end
        return w;
    endfunction

    function automatic logic is_eligible(input src_cfg_t c);
        return c.req && c.en && (c.tgt == TGT_CPU) && (c.prio != '0);
    endfunction

endpackage

// File: rtl/irq_src_reg.sv
module irq_src_reg
    import irq_router_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  src_wr_t  wr,
    input  logic     hw_req,
    input  logic     ack_clr,
    output src_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (ack_clr) cfg.req <= 1'b0;
            if (wr_en) begin
                cfg.prio <= wr.prio;
                cfg.en   <= wr.en;
                cfg.tgt  <= wr.tgt;
                if (wr.set)      cfg.req <= 1'b1;
                else if (wr.clr) cfg.req <= 1'b0;
            end
            if (hw_req) cfg.req <= 1'b1;
        end
    end

    a_r3_hw_wins: assert property (@(posedge clk) disable iff (rst)
        hw_req |=> cfg.req);
    a_r3_sw_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr.clr && !wr.set && !hw_req) |=> !cfg.req);
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_clr && !hw_req && !(wr_en && wr.set)) |=> !cfg.req);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_router_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  src_cfg_t             cfg [NSRC],
    output logic                 win_valid,
    output logic [IW-1:0]        win_idx,
    output logic [PRIO_BITS-1:0] win_prio
);
    logic [NSRC-1:0] elig;

    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        assign elig[g] = is_eligible(cfg[g]);
    end

    // strict greater-than keeps the lowest index on ties
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (cfg[i].prio > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                win_prio  = cfg[i].prio;
            end
        end
    end

    // R6 / R5: no eligible source outranks the winner, none before it ties
    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int j = 0; j < NSRC; j++) begin
                a_r6_no_better_source: assert (!elig[j] ||
                    (cfg[j].prio < win_prio) ||
                    (cfg[j].prio == win_prio && IW'(j) >= win_idx));
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gen_sel,
    input  logic [NSRC-1:0]      hw_req,
    input  logic                 bus_wr,
    input  logic [IW-1:0]        bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 cpu_ack,
    input  logic [PRIO_BITS-1:0] cpu_ack_prio,
    output logic                 irq_valid,
    output logic [PRIO_BITS-1:0] irq_prio,
    output logic [IW-1:0]        irq_src
);
    src_cfg_t        cfg [NSRC];
    src_wr_t         wr_fields;
    logic [NSRC-1:0] ack_clr;
    logic            addr_ok;

    logic                 win_valid;
    logic [IW-1:0]        win_idx;
    logic [PRIO_BITS-1:0] win_prio;

    assign wr_fields = unpack_word(gen_sel, bus_wdata);
    assign addr_ok   = (32'(bus_addr) < NSRC);

    // acknowledge: first eligible source carrying the accepted priority
    always_comb begin
        logic found;
        found   = 1'b0;
        ack_clr = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cpu_ack && !found && is_eligible(cfg[i]) && cfg[i].prio == cpu_ack_prio) begin
                ack_clr[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        irq_src_reg u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus_wr && addr_ok && (bus_addr == IW'(g))),
            .wr      (wr_fields),
            .hw_req  (hw_req[g]),
            .ack_clr (ack_clr[g]),
            .cfg     (cfg[g])
        );
    end

    irq_arbiter #(.NSRC(NSRC)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) bus_rdata = pack_word(gen_sel, cfg[bus_addr]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid <= 1'b0;
            irq_prio  <= '0;
            irq_src   <= '0;
        end else begin
            irq_valid <= win_valid;
            irq_prio  <= win_prio;
            irq_src   <= win_idx;
        end
    end

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> (irq_prio == '0 && irq_src == '0));
    a_r5_valid_nonzero: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_prio != '0));
    a_r9_one_ack_clear: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_clr));
    a_r8_follows_arbiter: assert property (@(posedge clk) disable iff (rst)
        win_valid |=> irq_valid);
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
    localparam int NSRC = 8;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            gen_sel = 1'b0;
    logic [NSRC-1:0] hw_req = '0;
    logic            bus_wr = 1'b0;
    logic [IW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            cpu_ack = 1'b0;
    logic [7:0]      cpu_ack_prio = '0;
    logic            irq_valid;
    logic [7:0]      irq_prio;
    logic [IW-1:0]   irq_src;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_router #(.NSRC(NSRC)) u0 (.*);

    function automatic logic [31:0] w0(int p, bit en, int t, bit s, bit c);
        return 32'(p) | (32'(en) << 10) | (32'(t) << 11) | (32'(s) << 26) | (32'(c) << 25);
    endfunction
    function automatic logic [31:0] w1(int p, bit en, int t, bit s, bit c);
        return 32'(p) | (32'(en) << 23) | (32'(t) << 12) | (32'(s) << 30) | (32'(c) << 29);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, bit v, int p, int s);
        chk(req, {30'd0, irq_valid, 1'b0}, {30'd0, v, 1'b0});
        chk(req, 32'(irq_prio), 32'(p));
        chk(req, 32'(irq_src), 32'(s));
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = IW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, logic [31:0] exp);
        bus_addr = IW'(a);
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic ack(int p);
        cpu_ack = 1'b1; cpu_ack_prio = 8'(p);
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk_out("R10", 0, 0, 0);
        for (int i = 0; i < NSRC; i++) rd_chk("R10", i, 32'h0);
    endtask

    task automatic t_layout0();
        wr(2, w0(5, 1, 1, 1, 0));
        rd_chk("R1", 2, 32'h01000C05);
        @(negedge clk);
        chk_out("R4", 0, 0, 0); // target not CPU
    endtask

    task automatic t_layout1();
        gen_sel = 1'b1;
        rd_chk("R2", 2, 32'h80801005);
        wr(3, w1(9, 1, 0, 1, 0));
        rd_chk("R2", 3, 32'h80800009);
        @(negedge clk);
        chk_out("R5", 1, 9, 3);
        gen_sel = 1'b0;
    endtask

    task automatic t_priority_latency();
        wr(4, w0(20, 1, 0, 1, 0));
        chk_out("R8", 1, 9, 3);   // one edge since update: still old
        @(negedge clk);
        chk_out("R5", 1, 20, 4);
    endtask

    task automatic t_tie();
        wr(1, w0(20, 1, 0, 1, 0));
        @(negedge clk);
        chk_out("R6", 1, 20, 1);
    endtask

    task automatic t_ineligible();
        wr(5, w0(0, 1, 0, 1, 0));
        @(negedge clk);
        chk_out("R4", 1, 20, 1);  // priority zero never wins
        wr(1, w0(20, 0, 0, 0, 0));
        rd_chk("R3", 1, 32'h01000014); // flag kept, no set/clear
        @(negedge clk);
        chk_out("R4", 1, 20, 4);
    endtask

    task automatic t_ack();
        ack(7);
        @(negedge clk);
        chk_out("R9", 1, 20, 4);
        rd_chk("R9", 4, 32'h01000414);
        ack(20);
        rd_chk("R9", 4, 32'h00000414);
        rd_chk("R9", 1, 32'h01000014); // disabled source untouched
        chk_out("R8", 1, 20, 4);
        @(negedge clk);
        chk_out("R9", 1, 9, 3);
    endtask

    task automatic t_hw();
        wr(6, w0(30, 1, 0, 0, 0));
        @(negedge clk);
        chk_out("R3", 1, 9, 3);
        hw_req[6] = 1'b1;
        @(negedge clk);
        hw_req[6] = 1'b0;
        @(negedge clk);
        chk_out("R3", 1, 30, 6);
        hw_req[6] = 1'b1;
        wr(6, w0(30, 1, 0, 0, 1));
        hw_req[6] = 1'b0;
        rd_chk("R3", 6, 32'h0100041E);
        @(negedge clk);
        chk_out("R3", 1, 30, 6);
        wr(6, w0(30, 1, 0, 0, 1));
        rd_chk("R3", 6, 32'h0000041E);
        @(negedge clk);
        chk_out("R3", 1, 9, 3);
    endtask

    task automatic t_idle();
        for (int i = 0; i < NSRC; i++) wr(i, w0(1, 1, 0, 0, 1));
        @(negedge clk);
        chk_out("R7", 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout0();
        t_layout1();
        t_priority_latency();
        t_tie();
        t_ineligible();
        t_ack();
        t_hw();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule